// File: doc/BRIEF.md
# Page-Add Request Fault Checker

This block judges a single request to install a fresh page into an already running protected region. The requester presents the request's operands as ports: where its descriptor sits, the destination frame, an optional pointer to a security-info record, the region's control page, the linear address to map and a source-page field that must be empty. Alongside these come lookup results for the destination frame and the control page, the control page's state (locked, initialised, base and size of the region), the security-info flags already fetched, and four mode bits. Fetching any of these from memory is the job of the surrounding logic.

A request is accepted on a one-cycle `req_valid` strobe. The operands are captured into a register stage and evaluated by an ordered cascade. The verdict is registered again and appears with `rsp_valid` two cycles after the strobe. The verdict is exactly one of: success, general fault, page fault (with the faulting address), or a conflict exit to the hypervisor. On success the block also hands the page installer the effective attributes of the new page. These are either the supplied flags or a default set when no security-info pointer is given.

A new request may be presented on every cycle, and each produces exactly one verdict.

Top module: `pgadd_fault_chk`

## Requirements
- R1: While `rst_n` is low at a rising edge, and on the edge after, `rsp_valid` is 0 and all response fields are 0.
- R2: Each cycle with `req_valid` high yields exactly one cycle of `rsp_valid` high, two rising edges later. Back-to-back requests are supported. Whenever `rsp_valid` is low, `rsp_code`, `rsp_fault_addr` and all `attr_*` outputs are 0.
- R3: A descriptor address not 32-byte aligned, or a destination address not page aligned (page = 2^PG_SHIFT bytes, 4 KiB by default), gives a general fault (`rsp_code` 2'b01).
- R4: A destination outside protected memory (`dst_in_prot`=0) gives a page fault (`rsp_code` 2'b10) with `rsp_fault_addr` = destination address.
- R5: The following each give a general fault: a nonzero security-info pointer that is not 64-byte aligned; a control-page address not page aligned; a linear address not page aligned; a nonzero source-page field. After those, a control page outside protected memory gives a page fault on the control-page address.
- R6: A destination in use gives `rsp_code` 2'b11 with `rsp_fault_addr` = destination when both `virt_mode` and `exit_on_conflict` are 1. Otherwise it gives a general fault.
- R7: A destination already valid gives a page fault on the destination.
- R8: A zero security-info pointer selects default attributes: type 1 (regular), read 1, write 1, execute 0. In this case the supplied `si_*` flags and `ss_feature` have no effect.
- R9: With a nonzero pointer, a general fault results if any of these holds: `si_rsvd_set` is 1; `ss_feature` is 0; `si_type` is not 5 (shadow-stack first) or 6 (shadow-stack rest); `si_read` is 0; `si_write` is 0; `si_exec` is 1.
- R10: An effective shadow-stack type (5 or 6) with `ss_enable` 0 gives a general fault.
- R11: A locked control page gives a general fault. Next, a control page not valid, or with type other than 0 (control), gives a page fault on the control-page address. Next, an uninitialised region gives a general fault.
- R12: A linear address below `ctrl_base`, or at or above `ctrl_base + ctrl_size` (computed without wrap), gives a general fault.
- R13: A shadow-stack page whose linear address equals the base, or equals base + size − one page, gives a general fault.
- R14: The checks are applied in the order R3, R4, R5, R6, R7, R9, R10, R11, R12, R13, and the first failing check decides the verdict. `rsp_fault_addr` is 0 unless the code is 2'b10 or 2'b11. The `attr_*` outputs are 0 unless the code is 2'b00, in which case `attr_lin` equals the linear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| desc_addr | input | AW | Request descriptor address |
| dst_addr | input | AW | Destination frame address |
| secinfo_ptr | input | AW | Security-info record pointer, 0 = use defaults |
| ctrl_addr | input | AW | Control-page address |
| lin_addr | input | AW | Linear address to map |
| src_page | input | AW | Source-page field, must be 0 |
| dst_in_prot | input | 1 | Destination lies in protected memory |
| dst_busy | input | 1 | Destination frame in use by another agent |
| dst_valid | input | 1 | Destination frame already valid |
| ctrl_in_prot | input | 1 | Control page lies in protected memory |
| ctrl_valid | input | 1 | Control page entry valid |
| ctrl_type | input | 8 | Control page entry type |
| ctrl_locked | input | 1 | Control page locked by another agent |
| ctrl_inited | input | 1 | Region has been initialised |
| ctrl_base | input | AW | Region base linear address |
| ctrl_size | input | AW | Region size in bytes |
| si_read | input | 1 | Supplied read permission |
| si_write | input | 1 | Supplied write permission |
| si_exec | input | 1 | Supplied execute permission |
| si_type | input | 8 | Supplied page type |
| si_rsvd_set | input | 1 | Some reserved security-info bit is nonzero |
| virt_mode | input | 1 | Running under a hypervisor |
| exit_on_conflict | input | 1 | Conflicts exit to the hypervisor |
| ss_enable | input | 1 | Shadow stacks enabled |
| ss_feature | input | 1 | Shadow-stack page types supported |
| rsp_valid | output | 1 | Verdict valid |
| rsp_code | output | 2 | 00 ok, 01 general fault, 10 page fault, 11 conflict exit |
| rsp_fault_addr | output | AW | Faulting address for codes 10 and 11 |
| attr_read | output | 1 | Effective read permission |
| attr_write | output | 1 | Effective write permission |
| attr_exec | output | 1 | Effective execute permission |
| attr_type | output | 8 | Effective page type |
| attr_lin | output | AW | Linear address to record |

## Verification
The bench instantiates the block with AW = 32 and the default 4 KiB page. With 32-bit addresses, a region ending exactly at the top of the address space can be built. This exercises the unwrapped end-of-range sum and the last-page shadow-stack test at the wrap point. The narrow width also keeps every misaligned-bit case in hand-written stimulus. Requests are issued back to back and between idle cycles, with one rule broken at a time and several broken together, to test cascade priority against a behavioural model.

// File: rtl/pgadd_pkg.sv
// Package: shared encodings for the page-add fault checker.
// Assumes 8-bit page types; result codes fixed as listed below.
package pgadd_pkg;

    typedef logic [7:0] ptype_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'b00,
        RES_GEN   = 2'b01,
        RES_PAGE  = 2'b10,
        RES_VMEXIT = 2'b11
    } res_code_t;

    localparam ptype_t PT_CTRL     = 8'd0;
    localparam ptype_t PT_REGULAR  = 8'd1;
    localparam ptype_t PT_SS_FIRST = 8'd5;
    localparam ptype_t PT_SS_REST  = 8'd6;

endpackage

// File: rtl/pgadd_align_chk.sv
// Module: flags an address whose low SH bits are not all zero.
// Assumes 1 <= SH < AW.
module pgadd_align_chk #(
    parameter int AW = 64,
    parameter int SH = 12
) (
    input  logic [AW-1:0] addr,
    output logic          misaligned
);
    // Any set bit below the alignment boundary means misaligned.
    always_comb misaligned = |addr[SH-1:0];
endmodule

// File: rtl/pgadd_attr_sel.sv
// Module: picks effective page attributes (default set or supplied
// flags) and validates supplied flags. Purely combinational.
// Assumes the caller says whether the pointer is zero.
module pgadd_attr_sel
    import pgadd_pkg::*;
(
    input  logic   ptr_zero,
    input  logic   si_read,
    input  logic   si_write,
    input  logic   si_exec,
    input  ptype_t si_type,
    input  logic   si_rsvd_set,
    input  logic   ss_feature,
    output logic   eff_read,
    output logic   eff_write,
    output logic   eff_exec,
    output ptype_t eff_type,
    output logic   eff_is_ss,
    output logic   flags_bad
);
    logic sup_is_ss;

    // Classify the supplied type as a shadow-stack kind.
    always_comb sup_is_ss = (si_type == PT_SS_FIRST) || (si_type == PT_SS_REST);

    // Supplied flags are judged only when a pointer is given.
    always_comb flags_bad = !ptr_zero &&
        (si_rsvd_set || !ss_feature || !sup_is_ss || !si_read || !si_write || si_exec);

    // Choose between the default attribute set and the supplied one.
    always_comb begin
        if (ptr_zero) begin
            eff_read  = 1'b1;
            eff_write = 1'b1;
            eff_exec  = 1'b0;
            eff_type  = PT_REGULAR;
        end else begin
            eff_read  = si_read;
            eff_write = si_write;
            eff_exec  = si_exec;
            eff_type  = si_type;
        end
    end

    // Effective shadow-stack flag drives the later enable and edge rules.
    always_comb eff_is_ss = (eff_type == PT_SS_FIRST) || (eff_type == PT_SS_REST);
endmodule

// File: rtl/pgadd_range_chk.sv
// Module: tests a linear address against the region window and the
// shadow-stack first/last page exclusion. End computed on AW+1 bits
// so base+size never wraps. Assumes size is a multiple of the page.
module pgadd_range_chk #(
    parameter int AW       = 64,
    parameter int PG_SHIFT = 12
) (
    input  logic [AW-1:0] lin_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic          is_ss,
    output logic          out_of_range,
    output logic          ss_edge
);
    localparam logic [AW:0] PG_BYTES = {{AW{1'b0}}, 1'b1} << PG_SHIFT;

    logic [AW:0] lin_x;
    logic [AW:0] end_x;
    logic [AW:0] last_x;

    // Widen operands and form the exclusive end and last page.
    always_comb begin
        lin_x  = {1'b0, lin_addr};
        end_x  = {1'b0, base} + {1'b0, size};
        last_x = end_x - PG_BYTES;
    end

    // Window test: below base or at/after the end is outside.
    always_comb out_of_range = (lin_addr < base) || (lin_x >= end_x);

    // Shadow-stack pages may not sit on the first or last page.
    always_comb ss_edge = is_ss && ((lin_addr == base) || (lin_x == last_x));
endmodule

// File: rtl/pgadd_fault_chk.sv
// Module: page-add request fault checker (top). Captures a request on
// req_valid, runs the ordered fault cascade on the captured operands,
// and registers one verdict two edges after the strobe.
// Assumes lookup and flag inputs are stable alongside req_valid.
module pgadd_fault_chk
    import pgadd_pkg::*;
#(
    parameter int AW         = 64,
    parameter int PG_SHIFT   = 12,
    parameter int DESC_ALIGN = 5,
    parameter int SI_ALIGN   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] desc_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] secinfo_ptr,
    input  logic [AW-1:0] ctrl_addr,
    input  logic [AW-1:0] lin_addr,
    input  logic [AW-1:0] src_page,
    input  logic          dst_in_prot,
    input  logic          dst_busy,
    input  logic          dst_valid,
    input  logic          ctrl_in_prot,
    input  logic          ctrl_valid,
    input  logic [7:0]    ctrl_type,
    input  logic          ctrl_locked,
    input  logic          ctrl_inited,
    input  logic [AW-1:0] ctrl_base,
    input  logic [AW-1:0] ctrl_size,
    input  logic          si_read,
    input  logic          si_write,
    input  logic          si_exec,
    input  logic [7:0]    si_type,
    input  logic          si_rsvd_set,
    input  logic          virt_mode,
    input  logic          exit_on_conflict,
    input  logic          ss_enable,
    input  logic          ss_feature,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [AW-1:0] rsp_fault_addr,
    output logic          attr_read,
    output logic          attr_write,
    output logic          attr_exec,
    output logic [7:0]    attr_type,
    output logic [AW-1:0] attr_lin
);
    localparam int NADDR = 5;   // addresses needing alignment checks

    // ---- captured request ----
    logic          s1_valid;
    logic [AW-1:0] s1_desc, s1_dst, s1_si, s1_ctrl, s1_lin, s1_src, s1_base, s1_size;
    logic          s1_dprot, s1_dbusy, s1_dvalid, s1_cprot, s1_cvalid, s1_clock, s1_cinit;
    ptype_t        s1_ctype, s1_sitype;
    logic          s1_sir, s1_siw, s1_six, s1_sirsvd;
    logic          s1_virt, s1_exit, s1_ssen, s1_ssfeat;

    // Capture operands when a request is strobed; validity every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= req_valid;
        end
        if (req_valid) begin
            s1_desc   <= desc_addr;
            s1_dst    <= dst_addr;
            s1_si     <= secinfo_ptr;
            s1_ctrl   <= ctrl_addr;
            s1_lin    <= lin_addr;
            s1_src    <= src_page;
            s1_base   <= ctrl_base;
            s1_size   <= ctrl_size;
            s1_dprot  <= dst_in_prot;
            s1_dbusy  <= dst_busy;
            s1_dvalid <= dst_valid;
            s1_cprot  <= ctrl_in_prot;
            s1_cvalid <= ctrl_valid;
            s1_clock  <= ctrl_locked;
            s1_cinit  <= ctrl_inited;
            s1_ctype  <= ctrl_type;
            s1_sitype <= si_type;
            s1_sir    <= si_read;
            s1_siw    <= si_write;
            s1_six    <= si_exec;
            s1_sirsvd <= si_rsvd_set;
            s1_virt   <= virt_mode;
            s1_exit   <= exit_on_conflict;
            s1_ssen   <= ss_enable;
            s1_ssfeat <= ss_feature;
        end
    end

    // ---- alignment checks, one checker per address ----
    logic [NADDR-1:0][AW-1:0] al_addr;
    logic [NADDR-1:0]         al_mis;
    localparam int AL_DESC = 0, AL_DST = 1, AL_SI = 2, AL_CTRL = 3, AL_LIN = 4;

    // Route captured addresses to the alignment checkers.
    always_comb begin
        al_addr[AL_DESC] = s1_desc;
        al_addr[AL_DST]  = s1_dst;
        al_addr[AL_SI]   = s1_si;
        al_addr[AL_CTRL] = s1_ctrl;
        al_addr[AL_LIN]  = s1_lin;
    end

    for (genvar g = 0; g < NADDR; g++) begin : g_align
        localparam int SH = (g == AL_DESC) ? DESC_ALIGN :
                            (g == AL_SI)   ? SI_ALIGN   : PG_SHIFT;
        pgadd_align_chk #(.AW(AW), .SH(SH)) u_al (
            .addr       (al_addr[g]),
            .misaligned (al_mis[g])
        );
    end

    // ---- attribute selection ----
    logic   ptr_zero, eff_r, eff_w, eff_x, eff_ss, si_bad;
    ptype_t eff_t;

    // A zero pointer selects the default attribute path.
    always_comb ptr_zero = (s1_si == '0);

    pgadd_attr_sel u_attr (
        .ptr_zero    (ptr_zero),
        .si_read     (s1_sir),
        .si_write    (s1_siw),
        .si_exec     (s1_six),
        .si_type     (s1_sitype),
        .si_rsvd_set (s1_sirsvd),
        .ss_feature  (s1_ssfeat),
        .eff_read    (eff_r),
        .eff_write   (eff_w),
        .eff_exec    (eff_x),
        .eff_type    (eff_t),
        .eff_is_ss   (eff_ss),
        .flags_bad   (si_bad)
    );

    // ---- region window ----
    logic oor, ss_edge;

    pgadd_range_chk #(.AW(AW), .PG_SHIFT(PG_SHIFT)) u_range (
        .lin_addr     (s1_lin),
        .base         (s1_base),
        .size         (s1_size),
        .is_ss        (eff_ss),
        .out_of_range (oor),
        .ss_edge      (ss_edge)
    );

    // ---- ordered fault cascade ----
    res_code_t     v_code;
    logic [AW-1:0] v_addr;

    // First failing rule in priority order decides the verdict.
    always_comb begin
        v_code = RES_OK;
        v_addr = '0;
        if (al_mis[AL_DESC] || al_mis[AL_DST]) begin
            v_code = RES_GEN;
        end else if (!s1_dprot) begin
            v_code = RES_PAGE;
            v_addr = s1_dst;
        end else if ((!ptr_zero && al_mis[AL_SI]) || al_mis[AL_CTRL] ||
                     al_mis[AL_LIN] || (s1_src != '0)) begin
            v_code = RES_GEN;
        end else if (!s1_cprot) begin
            v_code = RES_PAGE;
            v_addr = s1_ctrl;
        end else if (s1_dbusy) begin
            if (s1_virt && s1_exit) begin
                v_code = RES_VMEXIT;
                v_addr = s1_dst;
            end else begin
                v_code = RES_GEN;
            end
        end else if (s1_dvalid) begin
            v_code = RES_PAGE;
            v_addr = s1_dst;
        end else if (si_bad || (eff_ss && !s1_ssen) || s1_clock) begin
            v_code = RES_GEN;
        end else if (!s1_cvalid || (s1_ctype != PT_CTRL)) begin
            v_code = RES_PAGE;
            v_addr = s1_ctrl;
        end else if (!s1_cinit || oor || ss_edge) begin
            v_code = RES_GEN;
        end
    end

    // Register the verdict; idle cycles drive all fields to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !s1_valid) begin
            rsp_valid      <= 1'b0;
            rsp_code       <= 2'b00;
            rsp_fault_addr <= '0;
            attr_read      <= 1'b0;
            attr_write     <= 1'b0;
            attr_exec      <= 1'b0;
            attr_type      <= '0;
            attr_lin       <= '0;
        end else begin
            rsp_valid      <= 1'b1;
            rsp_code       <= v_code;
            rsp_fault_addr <= v_addr;
            attr_read      <= (v_code == RES_OK) && eff_r;
            attr_write     <= (v_code == RES_OK) && eff_w;
            attr_exec      <= (v_code == RES_OK) && eff_x;
            attr_type      <= (v_code == RES_OK) ? eff_t  : '0;
            attr_lin       <= (v_code == RES_OK) ? s1_lin : '0;
        end
    end
endmodule

// File: rtl/pgadd_fault_chk_sva.sv
// Checker: port-level properties of the page-add fault checker,
// bound to every instance of the top module.
module pgadd_fault_chk_sva #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] dst_addr,
    input logic [AW-1:0] ctrl_addr,
    input logic [AW-1:0] secinfo_ptr,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code,
    input logic [AW-1:0] rsp_fault_addr,
    input logic          attr_read,
    input logic          attr_write,
    input logic          attr_exec,
    input logic [7:0]    attr_type,
    input logic [AW-1:0] attr_lin
);
    // R1: the edge after a reset cycle shows no response.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rsp_valid);

    // R2: every request yields a response two edges later.
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R2: no response without a request two edges earlier.
    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    // R2: idle outputs are zero.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_code == 2'b00 && rsp_fault_addr == '0 && attr_lin == '0));

    // R6: a conflict exit reports the destination.
    a_r6_exit_reports_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b11) |-> rsp_fault_addr == $past(dst_addr, 2));

    // R4 / R11: a page fault names either the destination or the control page.
    a_r4_pf_addr_source: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b10) |->
            (rsp_fault_addr == $past(dst_addr, 2) || rsp_fault_addr == $past(ctrl_addr, 2)));

    // R8: a zero pointer that succeeds carries the default attributes.
    a_r8_default_attrs: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00 && $past(secinfo_ptr, 2) == '0) |->
            (attr_read && attr_write && !attr_exec && attr_type == 8'd1));

    // R14: a general fault carries no address.
    a_r14_gen_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 2'b01) |-> rsp_fault_addr == '0);

    // R14: attributes only accompany success.
    a_r14_attrs_on_ok_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 2'b00) |->
            (!attr_read && !attr_write && !attr_exec && attr_type == '0 && attr_lin == '0));
endmodule

bind pgadd_fault_chk pgadd_fault_chk_sva #(.AW(AW)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .dst_addr       (dst_addr),
    .ctrl_addr      (ctrl_addr),
    .secinfo_ptr    (secinfo_ptr),
    .rsp_valid      (rsp_valid),
    .rsp_code       (rsp_code),
    .rsp_fault_addr (rsp_fault_addr),
    .attr_read      (attr_read),
    .attr_write     (attr_write),
    .attr_exec      (attr_exec),
    .attr_type      (attr_type),
    .attr_lin       (attr_lin)
);

// File: tb/pgadd_fault_chk_tb_top.sv
// Bench: drives requests at falling edges, keeps a two-slot behavioural
// model of the verdict pipeline, compares every output on every cycle.
module pgadd_fault_chk_tb_top;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic          req_valid;
    logic [AW-1:0] desc_addr, dst_addr, secinfo_ptr, ctrl_addr, lin_addr, src_page;
    logic          dst_in_prot, dst_busy, dst_valid, ctrl_in_prot, ctrl_valid;
    logic [7:0]    ctrl_type, si_type;
    logic          ctrl_locked, ctrl_inited;
    logic [AW-1:0] ctrl_base, ctrl_size;
    logic          si_read, si_write, si_exec, si_rsvd_set;
    logic          virt_mode, exit_on_conflict, ss_enable, ss_feature;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic [AW-1:0] rsp_fault_addr;
    logic          attr_read, attr_write, attr_exec;
    logic [7:0]    attr_type;
    logic [AW-1:0] attr_lin;

    pgadd_fault_chk #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .desc_addr(desc_addr), .dst_addr(dst_addr), .secinfo_ptr(secinfo_ptr),
        .ctrl_addr(ctrl_addr), .lin_addr(lin_addr), .src_page(src_page),
        .dst_in_prot(dst_in_prot), .dst_busy(dst_busy), .dst_valid(dst_valid),
        .ctrl_in_prot(ctrl_in_prot), .ctrl_valid(ctrl_valid), .ctrl_type(ctrl_type),
        .ctrl_locked(ctrl_locked), .ctrl_inited(ctrl_inited),
        .ctrl_base(ctrl_base), .ctrl_size(ctrl_size),
        .si_read(si_read), .si_write(si_write), .si_exec(si_exec),
        .si_type(si_type), .si_rsvd_set(si_rsvd_set),
        .virt_mode(virt_mode), .exit_on_conflict(exit_on_conflict),
        .ss_enable(ss_enable), .ss_feature(ss_feature),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_fault_addr(rsp_fault_addr),
        .attr_read(attr_read), .attr_write(attr_write), .attr_exec(attr_exec),
        .attr_type(attr_type), .attr_lin(attr_lin)
    );

    typedef struct {
        logic [31:0] desc, dst, siptr, ctrl, lin, src, base, size;
        bit dprot, dbusy, dvalid, cprot, cvalid, clock, cinit;
        logic [7:0] ctype, sitype;
        bit sir, siw, six, sirsvd, virt, xen, ssen, feat;
    } req_s;

    typedef struct {
        bit vld;
        logic [1:0] code;
        logic [31:0] addr;
        bit r, w, x;
        logic [7:0] typ;
        logic [31:0] lin;
        string tag;
    } exp_s;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_s m1, m2;

    function automatic exp_s idle_exp(string tag);
        exp_s e;
        e.vld = 0; e.code = 0; e.addr = 0; e.r = 0; e.w = 0; e.x = 0;
        e.typ = 0; e.lin = 0; e.tag = tag;
        return e;
    endfunction

    function automatic req_s base_req();
        req_s q;
        q.desc = 32'h1000_0040; q.dst = 32'h2000_3000; q.siptr = 32'h0;
        q.ctrl = 32'h3000_0000; q.lin = 32'h4000_5000; q.src = 32'h0;
        q.base = 32'h4000_0000; q.size = 32'h0010_0000;
        q.dprot = 1; q.dbusy = 0; q.dvalid = 0; q.cprot = 1; q.cvalid = 1;
        q.clock = 0; q.cinit = 1; q.ctype = 8'd0; q.sitype = 8'd6;
        q.sir = 1; q.siw = 1; q.six = 0; q.sirsvd = 0;
        q.virt = 0; q.xen = 0; q.ssen = 1; q.feat = 1;
        return q;
    endfunction

    // Behavioural verdict straight from the rule list.
    function automatic exp_s model(req_s q, string tag);
        exp_s e;
        longint unsigned lo, hi, la;
        bit is_ss;
        logic [7:0] et;
        e = idle_exp(tag);
        e.vld = 1;
        et = (q.siptr == 0) ? 8'd1 : q.sitype;
        is_ss = (et == 8'd5) || (et == 8'd6);
        lo = q.base;
        hi = longint'(q.base) + longint'(q.size);
        la = q.lin;
        if (q.desc % 32 != 0 || q.dst % 4096 != 0) e.code = 1;
        else if (!q.dprot) begin e.code = 2; e.addr = q.dst; end
        else if ((q.siptr != 0 && q.siptr % 64 != 0) || q.ctrl % 4096 != 0 ||
                 q.lin % 4096 != 0 || q.src != 0) e.code = 1;
        else if (!q.cprot) begin e.code = 2; e.addr = q.ctrl; end
        else if (q.dbusy) begin
            if (q.virt && q.xen) begin e.code = 3; e.addr = q.dst; end
            else e.code = 1;
        end
        else if (q.dvalid) begin e.code = 2; e.addr = q.dst; end
        else if (q.siptr != 0 && (q.sirsvd || !q.feat || !(q.sitype == 5 || q.sitype == 6) ||
                 !q.sir || !q.siw || q.six)) e.code = 1;
        else if (is_ss && !q.ssen) e.code = 1;
        else if (q.clock) e.code = 1;
        else if (!q.cvalid || q.ctype != 0) begin e.code = 2; e.addr = q.ctrl; end
        else if (!q.cinit) e.code = 1;
        else if (la < lo || la >= hi) e.code = 1;
        else if (is_ss && (la == lo || la == hi - 4096)) e.code = 1;
        if (e.code == 0) begin
            if (q.siptr == 0) begin e.r = 1; e.w = 1; e.x = 0; end
            else begin e.r = q.sir; e.w = q.siw; e.x = q.six; end
            e.typ = et;
            e.lin = q.lin;
        end
        return e;
    endfunction

    task automatic chk(string tag, string fld, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, fld, act, exp);
        end
    endtask

    task automatic compare();
        chk(m2.tag, "rsp_valid", rsp_valid, m2.vld);
        chk(m2.tag, "rsp_code", rsp_code, m2.code);
        chk(m2.tag, "rsp_fault_addr", rsp_fault_addr, m2.addr);
        chk(m2.tag, "attr_read", attr_read, m2.r);
        chk(m2.tag, "attr_write", attr_write, m2.w);
        chk(m2.tag, "attr_exec", attr_exec, m2.x);
        chk(m2.tag, "attr_type", attr_type, m2.typ);
        chk(m2.tag, "attr_lin", attr_lin, m2.lin);
    endtask

    task automatic drive(req_s q, bit v);
        req_valid = v;
        desc_addr = q.desc; dst_addr = q.dst; secinfo_ptr = q.siptr;
        ctrl_addr = q.ctrl; lin_addr = q.lin; src_page = q.src;
        ctrl_base = q.base; ctrl_size = q.size;
        dst_in_prot = q.dprot; dst_busy = q.dbusy; dst_valid = q.dvalid;
        ctrl_in_prot = q.cprot; ctrl_valid = q.cvalid; ctrl_locked = q.clock;
        ctrl_inited = q.cinit; ctrl_type = q.ctype; si_type = q.sitype;
        si_read = q.sir; si_write = q.siw; si_exec = q.six; si_rsvd_set = q.sirsvd;
        virt_mode = q.virt; exit_on_conflict = q.xen; ss_enable = q.ssen; ss_feature = q.feat;
    endtask

    // One falling edge: check last verdict slot, advance model, drive.
    task automatic send(req_s q, string tag);
        @(negedge clk);
        compare();
        m2 = m1;
        drive(q, 1'b1);
        m1 = model(q, tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        compare();
        m2 = m1;
        drive(base_req(), 1'b0);
        m1 = idle_exp(tag);
    endtask

    initial begin
        req_s q;
        drive(base_req(), 1'b0);
        m1 = idle_exp("R1");
        m2 = idle_exp("R1");
        repeat (3) begin
            @(negedge clk);
            compare();   // R1: reset state, all outputs zero
        end
        rst_n = 1'b1;
        idle("R1");
        idle("R2");

        // R8: default attributes; supplied flags ignored with zero pointer
        q = base_req(); send(q, "R8");
        q = base_req(); q.sirsvd = 1; q.six = 1; q.feat = 0; q.sitype = 8'd9; send(q, "R8");
        idle("R2");
        // R3: descriptor and destination alignment
        q = base_req(); q.desc = 32'h1000_0050; send(q, "R3");
        q = base_req(); q.dst = 32'h2000_3800; send(q, "R3");
        q = base_req(); q.desc = 32'h1000_0044; q.dprot = 0; send(q, "R14");
        // R4
        q = base_req(); q.dprot = 0; q.src = 32'h1; send(q, "R4");
        // R5
        q = base_req(); q.siptr = 32'h0000_8020; send(q, "R5");
        q = base_req(); q.ctrl = 32'h3000_0100; send(q, "R5");
        q = base_req(); q.lin = 32'h4000_5010; send(q, "R5");
        q = base_req(); q.src = 32'h0000_1000; send(q, "R5");
        q = base_req(); q.cprot = 0; q.dbusy = 1; send(q, "R5");
        idle("R2");
        // R6
        q = base_req(); q.dbusy = 1; q.virt = 1; q.xen = 1; q.dvalid = 1; send(q, "R6");
        q = base_req(); q.dbusy = 1; q.virt = 1; send(q, "R6");
        q = base_req(); q.dbusy = 1; q.xen = 1; send(q, "R6");
        // R7
        q = base_req(); q.dvalid = 1; q.clock = 1; send(q, "R7");
        // R9: supplied flags
        q = base_req(); q.siptr = 32'h0000_8040; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.sitype = 8'd5; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.sirsvd = 1; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.feat = 0; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.sitype = 8'd1; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.sir = 0; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.siw = 0; send(q, "R9");
        q = base_req(); q.siptr = 32'h0000_8040; q.six = 1; send(q, "R9");
        // R10
        q = base_req(); q.siptr = 32'h0000_8040; q.ssen = 0; send(q, "R10");
        q = base_req(); q.ssen = 0; send(q, "R10");
        // R11
        q = base_req(); q.clock = 1; q.cvalid = 0; send(q, "R11");
        q = base_req(); q.cvalid = 0; q.cinit = 0; send(q, "R11");
        q = base_req(); q.ctype = 8'd1; send(q, "R11");
        q = base_req(); q.cinit = 0; send(q, "R11");
        idle("R2");
        // R12
        q = base_req(); q.lin = 32'h3FFF_F000; send(q, "R12");
        q = base_req(); q.lin = 32'h4010_0000; send(q, "R12");
        q = base_req(); q.lin = 32'h400F_F000; send(q, "R12");
        q = base_req(); q.lin = 32'h4000_0000; send(q, "R12");
        q = base_req(); q.base = 32'hFFF0_0000; q.lin = 32'hFFFF_F000; send(q, "R12");
        // R13
        q = base_req(); q.siptr = 32'h0000_8040; q.sitype = 8'd5; q.lin = 32'h4000_0000; send(q, "R13");
        q = base_req(); q.siptr = 32'h0000_8040; q.lin = 32'h400F_F000; send(q, "R13");
        q = base_req(); q.siptr = 32'h0000_8040; q.lin = 32'h4000_1000; send(q, "R13");
        q = base_req(); q.siptr = 32'h0000_8040; q.base = 32'hFFF0_0000;
        q.lin = 32'hFFFF_F000; send(q, "R13");
        idle("R2");
        idle("R2");
        idle("R2");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule